// File: doc/BRIEF.md
# Dual-Channel Transmit Shutdown and Fault Latch

This block decides, for each of two laser transmitters, when the laser must be turned off. Each channel has a disable pin and a software disable bit that acts exactly like the pin. It also has an external fault input whose polarity is set by a configuration bit, plus monitor flags for high transmit power, high bias and low transmit power. Each flag has its own enable bit. Enabled high-side faults and the external fault set a per-channel fast-shutdown latch. That latch forces the channel's disable output on, so the laser driver is switched off without software in the loop. Low transmit power is the one exception: it can latch the channel's fault, but it never causes a shutdown.

Every disable request is stretched into a settling window of `EXT_CYCLES` clock cycles after the request drops. While the window is open, the channel's low alarms and warnings are kept from latching, and so is its low-power fault. This lets the power control loop settle after a restart. The fault latches are cleared by power-on reset. They are also cleared by holding the disable request for `RST_CYCLES` consecutive clocks. Both times are counted in clock cycles.

A shared transmit-fault output, modelled as an open-drain pull-low, reports the latched faults of the channels selected for it. The disable outputs are only driven while the supply is above the power-on threshold. Below it they float, which is modelled as an output-enable that goes low.

Top module: `txctl_dual`

## Requirements
- R1: For each channel, `dis_out` is high whenever the disable pin, the software disable bit or that channel's `fetg` latch is high.
- R2: `dis_oe` is low (disable outputs high-impedance) whenever `supply_ok` is low, and high otherwise.
- R3: A channel's `win` is high while its disable request (pin OR software bit) is high, and for exactly `EXT_CYCLES` further clock edges after the request drops.
- R4: A bit of `lo_lat` (LO_W bits per channel, channel c at bits c*LO_W and up) is set at a clock edge where its `lo_evt` bit is high and that channel's `win` is low. It keeps its value while `win` is high, and stays set until reset.
- R5: `fetg` is set at a clock edge where high transmit power, high bias or the effective external fault is high together with its own enable bit, and it then holds.
- R6: Enabled low transmit power with `win` low sets the channel's `flt` latch but never sets `fetg`. Every `fetg` set also sets `flt`.
- R7: The effective external fault is `flt_pin` XOR `flt_inv` for that channel.
- R8: At a clock edge where the disable request is high and was also high at the previous `RST_CYCLES` edges, `flt` and `fetg` clear unless a set condition is present at that edge. Set wins over clear.
- R9: `txf_low` is high exactly when some channel has both `flt` and `txf_sel` high.
- R10: An active-low `rst_n` clears `flt`, `fetg`, `lo_lat` and both timers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply above power-on threshold |
| dis_pin | input | NCH | Transmit-disable pin per channel |
| sw_dis | input | NCH | Software disable bit per channel |
| flt_pin | input | NCH | External fault input per channel |
| flt_inv | input | NCH | Invert external fault polarity |
| flt_en | input | NCH | Enable external fault into shutdown |
| txp_hi | input | NCH | High transmit-power flag |
| txp_hi_en | input | NCH | Enable for high transmit power |
| bias_hi | input | NCH | High bias flag |
| bias_hi_en | input | NCH | Enable for high bias |
| txp_lo | input | NCH | Low transmit-power flag |
| txp_lo_en | input | NCH | Enable for low transmit power |
| lo_evt | input | NCH*LO_W | Low alarm/warning events to latch |
| txf_sel | input | NCH | Route channel fault to shared output |
| dis_out | output | NCH | Transmit-disable output value |
| dis_oe | output | 1 | Drive enable for disable outputs |
| txf_low | output | 1 | Shared fault, pull-low active |
| flt | output | NCH | Latched fault per channel |
| fetg | output | NCH | Fast-shutdown latch per channel |
| win | output | NCH | Extended-disable window per channel |
| lo_lat | output | NCH*LO_W | Latched low alarms and warnings |

## Verification
The bench drives disable requests of very different lengths. Short pulses test the settling-window tail. Holds longer than `RST_CYCLES` separate "the latch was cleared" from "the latch held". Holds just shorter than `RST_CYCLES` catch an off-by-one in the clear timer. Sparse high-side flag pulses under changing enable and polarity settings tell enabled faults apart from masked ones. Frequent low-power pulses show that the fault latch and the shutdown latch are kept apart. Low-event bursts that arrive just before, inside and after a window check the suppression edges. Supply drops and a mid-run reset check the output float and the clear of all state.

// File: rtl/txctl_pkg.sv
package txctl_pkg;

  typedef struct packed {
    logic txp_hi;
    logic txp_hi_en;
    logic bias_hi;
    logic bias_hi_en;
    logic ext;
    logic ext_en;
    logic txp_lo;
    logic txp_lo_en;
  } chan_flags_t;

  // Enabled causes that may force a shutdown (low power is excluded).
  function automatic logic fast_hit(chan_flags_t f);
    return (f.txp_hi & f.txp_hi_en) | (f.bias_hi & f.bias_hi_en) |
           (f.ext & f.ext_en);
  endfunction

  // Low-power fault, ignored while the settling window is open.
  function automatic logic slow_hit(chan_flags_t f, logic window);
    return f.txp_lo & f.txp_lo_en & ~window;
  endfunction

  // Set-dominant set/reset latch step.
  function automatic logic sr_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/txctl_stretch.sv
module txctl_stretch #(
  parameter int EXT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic win
);
  localparam int CW = $clog2(EXT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(EXT_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (req)             remain <= LOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign win = req | (remain != '0);
endmodule

// File: rtl/txctl_hold.sv
module txctl_hold #(
  parameter int RST_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic clr
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CYCLES);

  logic [CW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              held <= '0;
    else if (!req)           held <= '0;
    else if (held != LIMIT)  held <= held + 1'b1;
  end

  assign clr = req & (held == LIMIT);
endmodule

// File: rtl/txctl_chan.sv
module txctl_chan
  import txctl_pkg::*;
#(
  parameter int EXT_CYCLES = 8,
  parameter int RST_CYCLES = 20,
  parameter int LO_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dis_pin,
  input  logic            sw_dis,
  input  logic            flt_pin,
  input  logic            flt_inv,
  input  logic            flt_en,
  input  logic            txp_hi,
  input  logic            txp_hi_en,
  input  logic            bias_hi,
  input  logic            bias_hi_en,
  input  logic            txp_lo,
  input  logic            txp_lo_en,
  input  logic [LO_W-1:0] lo_evt,
  output logic            dis_out,
  output logic            flt_q,
  output logic            fetg_q,
  output logic            win,
  output logic [LO_W-1:0] lo_q
);
  logic        req;
  logic        clr;
  logic        set_fast;
  logic        set_slow;
  chan_flags_t flags;

  assign req = dis_pin | sw_dis;

  txctl_stretch #(.EXT_CYCLES(EXT_CYCLES)) u_stretch (
    .clk(clk), .rst_n(rst_n), .req(req), .win(win)
  );

  txctl_hold #(.RST_CYCLES(RST_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .req(req), .clr(clr)
  );

  always_comb begin
    flags            = '0;
    flags.txp_hi     = txp_hi;
    flags.txp_hi_en  = txp_hi_en;
    flags.bias_hi    = bias_hi;
    flags.bias_hi_en = bias_hi_en;
    flags.ext        = flt_pin ^ flt_inv;
    flags.ext_en     = flt_en;
    flags.txp_lo     = txp_lo;
    flags.txp_lo_en  = txp_lo_en;
  end

  assign set_fast = fast_hit(flags);
  assign set_slow = slow_hit(flags, win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetg_q <= 1'b0;
      flt_q  <= 1'b0;
      lo_q   <= '0;
    end else begin
      fetg_q <= sr_next(fetg_q, set_fast, clr);
      flt_q  <= sr_next(flt_q, set_fast | set_slow, clr);
      lo_q   <= lo_q | (lo_evt & ~{LO_W{win}});
    end
  end

  assign dis_out = req | fetg_q;
endmodule

// File: rtl/txctl_dual.sv
module txctl_dual #(
  parameter int NCH        = 2,
  parameter int LO_W       = 5,
  parameter int EXT_CYCLES = 8,
  parameter int RST_CYCLES = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 supply_ok,
  input  logic [NCH-1:0]       dis_pin,
  input  logic [NCH-1:0]       sw_dis,
  input  logic [NCH-1:0]       flt_pin,
  input  logic [NCH-1:0]       flt_inv,
  input  logic [NCH-1:0]       flt_en,
  input  logic [NCH-1:0]       txp_hi,
  input  logic [NCH-1:0]       txp_hi_en,
  input  logic [NCH-1:0]       bias_hi,
  input  logic [NCH-1:0]       bias_hi_en,
  input  logic [NCH-1:0]       txp_lo,
  input  logic [NCH-1:0]       txp_lo_en,
  input  logic [NCH*LO_W-1:0]  lo_evt,
  input  logic [NCH-1:0]       txf_sel,
  output logic [NCH-1:0]       dis_out,
  output logic                 dis_oe,
  output logic                 txf_low,
  output logic [NCH-1:0]       flt,
  output logic [NCH-1:0]       fetg,
  output logic [NCH-1:0]       win,
  output logic [NCH*LO_W-1:0]  lo_lat
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    txctl_chan #(
      .EXT_CYCLES(EXT_CYCLES), .RST_CYCLES(RST_CYCLES), .LO_W(LO_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_n),
      .dis_pin(dis_pin[c]), .sw_dis(sw_dis[c]),
      .flt_pin(flt_pin[c]), .flt_inv(flt_inv[c]), .flt_en(flt_en[c]),
      .txp_hi(txp_hi[c]), .txp_hi_en(txp_hi_en[c]),
      .bias_hi(bias_hi[c]), .bias_hi_en(bias_hi_en[c]),
      .txp_lo(txp_lo[c]), .txp_lo_en(txp_lo_en[c]),
      .lo_evt(lo_evt[c*LO_W +: LO_W]),
      .dis_out(dis_out[c]), .flt_q(flt[c]), .fetg_q(fetg[c]),
      .win(win[c]), .lo_q(lo_lat[c*LO_W +: LO_W])
    );
  end

  assign dis_oe  = supply_ok;
  assign txf_low = |(flt & txf_sel);
endmodule

// File: rtl/txctl_dual_chk.sv
module txctl_dual_chk #(
  parameter int NCH  = 2,
  parameter int LO_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                supply_ok,
  input logic [NCH-1:0]      dis_pin,
  input logic [NCH-1:0]      sw_dis,
  input logic [NCH-1:0]      flt_pin,
  input logic [NCH-1:0]      flt_inv,
  input logic [NCH-1:0]      flt_en,
  input logic [NCH-1:0]      txp_hi,
  input logic [NCH-1:0]      txp_hi_en,
  input logic [NCH-1:0]      bias_hi,
  input logic [NCH-1:0]      bias_hi_en,
  input logic [NCH-1:0]      txf_sel,
  input logic [NCH-1:0]      dis_out,
  input logic                dis_oe,
  input logic                txf_low,
  input logic [NCH-1:0]      flt,
  input logic [NCH-1:0]      fetg,
  input logic [NCH-1:0]      win,
  input logic [NCH*LO_W-1:0] lo_lat
);
  logic [NCH-1:0] req_c;
  logic [NCH-1:0] fast_c;
  assign req_c  = dis_pin | sw_dis;
  assign fast_c = ((flt_pin ^ flt_inv) & flt_en) | (txp_hi & txp_hi_en) |
                  (bias_hi & bias_hi_en);

  assert_shutdown_forces_dis_R1: assert property (@(posedge clk)
    disable iff (!rst_n) (dis_out & fetg) == fetg);

  assert_float_low_supply_R2: assert property (@(posedge clk)
    disable iff (!rst_n) !supply_ok |-> !dis_oe);

  assert_fetg_implies_flt_R6: assert property (@(posedge clk)
    disable iff (!rst_n) (fetg & ~flt) == '0);

  assert_shared_fault_R9: assert property (@(posedge clk)
    disable iff (!rst_n) ((flt & txf_sel) != '0) |-> txf_low);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_window_follows_req_R3: assert property (@(posedge clk)
      disable iff (!rst_n) req_c[c] |=> win[c]);

    assert_lo_frozen_in_window_R4: assert property (@(posedge clk)
      disable iff (!rst_n) win[c] |=> $stable(lo_lat[c*LO_W +: LO_W]));

    assert_fetg_needs_fast_cause_R5: assert property (@(posedge clk)
      disable iff (!rst_n) (!fetg[c] && !fast_c[c]) |=> !fetg[c]);
  end
endmodule

bind txctl_dual txctl_dual_chk #(.NCH(NCH), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
  .dis_pin(dis_pin), .sw_dis(sw_dis), .flt_pin(flt_pin), .flt_inv(flt_inv),
  .flt_en(flt_en), .txp_hi(txp_hi), .txp_hi_en(txp_hi_en),
  .bias_hi(bias_hi), .bias_hi_en(bias_hi_en), .txf_sel(txf_sel),
  .dis_out(dis_out), .dis_oe(dis_oe), .txf_low(txf_low), .flt(flt),
  .fetg(fetg), .win(win), .lo_lat(lo_lat)
);

// File: tb/txctl_dual_test.sv
module txctl_dual_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int LO_W = 5;
  localparam int EXT = 8;
  localparam int RST = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok;
  logic [NCH-1:0] dis_pin, sw_dis, flt_pin, flt_inv, flt_en;
  logic [NCH-1:0] txp_hi, txp_hi_en, bias_hi, bias_hi_en;
  logic [NCH-1:0] txp_lo, txp_lo_en, txf_sel;
  logic [NCH*LO_W-1:0] lo_evt;
  logic [NCH-1:0] dis_out, flt, fetg, win;
  logic dis_oe, txf_low;
  logic [NCH*LO_W-1:0] lo_lat;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int m_tail[NCH];
  int m_held[NCH];
  bit m_fetg[NCH];
  bit m_flt[NCH];
  bit [LO_W-1:0] m_lo[NCH];
  int hold_left[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  txctl_dual #(.NCH(NCH), .LO_W(LO_W), .EXT_CYCLES(EXT), .RST_CYCLES(RST)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .dis_pin(dis_pin), .sw_dis(sw_dis), .flt_pin(flt_pin), .flt_inv(flt_inv),
    .flt_en(flt_en), .txp_hi(txp_hi), .txp_hi_en(txp_hi_en),
    .bias_hi(bias_hi), .bias_hi_en(bias_hi_en), .txp_lo(txp_lo),
    .txp_lo_en(txp_lo_en), .lo_evt(lo_evt), .txf_sel(txf_sel),
    .dis_out(dis_out), .dis_oe(dis_oe), .txf_low(txf_low), .flt(flt),
    .fetg(fetg), .win(win), .lo_lat(lo_lat)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // advance the reference by one clock edge, then compare at the falling edge
  task automatic step();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      bit req, open, ext, fast, slow, clear;
      if (!rst_n) begin
        m_tail[c] = 0; m_held[c] = 0; m_fetg[c] = 0; m_flt[c] = 0; m_lo[c] = '0;
      end else begin
        req   = dis_pin[c] | sw_dis[c];
        open  = req || (m_tail[c] > 0);
        ext   = flt_pin[c] ^ flt_inv[c];                       // R7
        fast  = (txp_hi[c] && txp_hi_en[c]) || (bias_hi[c] && bias_hi_en[c]) ||
                (ext && flt_en[c]);
        slow  = txp_lo[c] && txp_lo_en[c] && !open;
        clear = req && (m_held[c] >= RST);                      // R8
        m_fetg[c] = fast ? 1'b1 : (clear ? 1'b0 : m_fetg[c]);
        m_flt[c]  = (fast || slow) ? 1'b1 : (clear ? 1'b0 : m_flt[c]);
        if (!open) m_lo[c] = m_lo[c] | lo_evt[c*LO_W +: LO_W];
        m_held[c] = req ? m_held[c] + 1 : 0;
        if (req) m_tail[c] = EXT;
        else if (m_tail[c] > 0) m_tail[c] = m_tail[c] - 1;
      end
    end
    begin
      logic [NCH-1:0] e_dis, e_flt, e_fetg, e_win;
      logic [NCH*LO_W-1:0] e_lo;
      bit e_txf;
      e_txf = 0;
      for (int c = 0; c < NCH; c++) begin
        e_dis[c]  = dis_pin[c] | sw_dis[c] | m_fetg[c];
        e_flt[c]  = m_flt[c];
        e_fetg[c] = m_fetg[c];
        e_win[c]  = dis_pin[c] | sw_dis[c] | (m_tail[c] > 0);
        e_lo[c*LO_W +: LO_W] = m_lo[c];
        if (m_flt[c] && txf_sel[c]) e_txf = 1;
      end
      if (!rst_n) begin
        chk("R10", "flt after reset", 32'(flt), 32'(e_flt));
        chk("R10", "fetg after reset", 32'(fetg), 32'(e_fetg));
        chk("R10", "lo_lat after reset", 32'(lo_lat), 32'(e_lo));
      end else begin
        chk("R1", "dis_out", 32'(dis_out), 32'(e_dis));
        chk("R2", "dis_oe", 32'(dis_oe), 32'(supply_ok));
        chk("R3", "win", 32'(win), 32'(e_win));
        chk("R4", "lo_lat", 32'(lo_lat), 32'(e_lo));
        chk("R5/R7/R8", "fetg", 32'(fetg), 32'(e_fetg));
        chk("R6/R8", "flt", 32'(flt), 32'(e_flt));
        chk("R9", "txf_low", 32'(txf_low), 32'(e_txf));
      end
    end
  endtask

  task automatic drive(int cyc);
    if (cyc % 97 == 0) begin
      flt_inv = NCH'($urandom); flt_en = NCH'($urandom);
      txp_hi_en = NCH'($urandom); bias_hi_en = NCH'($urandom);
      txp_lo_en = NCH'($urandom | $urandom); txf_sel = NCH'($urandom);
    end
    if (cyc % 53 == 0) supply_ok = ($urandom_range(0, 4) != 0);
    for (int c = 0; c < NCH; c++) begin
      if (hold_left[c] == 0) begin
        dis_pin[c] = ($urandom_range(0, 2) == 0);
        // lengths around the clear threshold and the window tail
        hold_left[c] = dis_pin[c] ? $urandom_range(1, RST + 6) : $urandom_range(3, 70);
      end
      hold_left[c]--;
      sw_dis[c]  = ($urandom_range(0, 59) == 0);
      txp_hi[c]  = ($urandom_range(0, 49) == 0);
      bias_hi[c] = ($urandom_range(0, 49) == 0);
      txp_lo[c]  = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 39) == 0) flt_pin[c] = ~flt_pin[c];
    end
    lo_evt = (NCH*LO_W)'($urandom & $urandom & $urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1;
    dis_pin = '0; sw_dis = '0; flt_pin = '0; flt_inv = '0; flt_en = '0;
    txp_hi = '0; txp_hi_en = '0; bias_hi = '0; bias_hi_en = '0;
    txp_lo = '0; txp_lo_en = '0; txf_sel = '1; lo_evt = '0;
    for (int c = 0; c < NCH; c++) begin
      m_tail[c] = 0; m_held[c] = 0; m_fetg[c] = 0; m_flt[c] = 0; m_lo[c] = '0;
      hold_left[c] = 0;
    end
    step(); step();                      // R10 reset state
    rst_n = 1'b1;
    step();

    // directed R6: enabled low power alone latches flt, never fetg
    txp_lo = 2'b01; txp_lo_en = 2'b01;
    step(); step();
    txp_lo = '0;
    step();
    // directed R7: inverted polarity turns an idle-low pin into a fault
    flt_inv = 2'b10; flt_en = 2'b10;
    step(); step();
    flt_en = '0;
    // directed R8: hold disable exactly long enough to clear
    dis_pin = '1;
    for (int k = 0; k < RST + 2; k++) step();
    dis_pin = '0;
    // directed R3/R4: events inside the tail are ignored, after are kept
    lo_evt = '1;
    for (int k = 0; k < EXT + 3; k++) step();
    lo_evt = '0;
    step();

    for (int cyc = 0; cyc < 6000; cyc++) begin
      drive(cyc);
      if (cyc == 3000) rst_n = 1'b0;      // R10 mid-run reset
      if (cyc == 3003) rst_n = 1'b1;
      step();
    end
    summary();
  end
endmodule